// File: doc/BRIEF.md
# E1 Timeslot-0 Spare-Bit Capture and Insertion

This block handles the spare (Sa) overhead bits that E1 frames carry in timeslot 0. On the receive side it watches a serial bit stream that an external frame aligner has already annotated with position strobes. These strobes give the timeslot-0 flag, the bit position inside the timeslot and the frame number inside the 16-frame multiframe. Sa4 to Sa8 sit in bit positions 4 to 8 of timeslot 0 in the odd-numbered frames, which are the ones without the alignment word. A capture starts at a multiframe boundary and spans two complete multiframes, which gives 80 bits held as sixteen 5-bit entries. A capture counts only while the aligner reports alignment. A finished capture is copied at once into a read snapshot, and a status flag is raised that software can mask and clear.

On the transmit side the block sits in the outgoing serial path. For each of the five Sa positions a select bit chooses the source. Either the bit comes from a sixteen-entry transmit table that software loads, or the system-side bit passes through unchanged. Every position that is not a selected Sa bit always carries the system-side bit.

Top module: `e1sa_datalink`

## Requirements
- R1: After reset every snapshot entry reads 0, and both `sts` and `irq` are 0.
- R2: In a capture, entry k = {m, f[3:1]} holds the timeslot-0 bits of odd frame f of multiframe m (0 or 1). Entry bit 4 is Sa4 (bit position 3 on `rx_bitpos`) and entry bit 0 is Sa8 (position 7). Bits from even frames, from positions 0 to 2, and from cycles with `rx_slot0`=0 never reach an entry.
- R3: A capture begins at frame 0 bit position 0 with alignment present. The snapshot changes only on the clock edge that samples Sa8 of frame 15 of the second multiframe, and in that case all sixteen entries change together.
- R4: A valid cycle with `rx_aligned`=0 discards the capture in progress. Nothing reaches the snapshot until a new two-multiframe capture, started at a later frame 0, completes.
- R5: `sts` becomes 1 on the edge that updates the snapshot. A 1 on `sts_clr` clears it on the next edge. If the set and the clear fall in the same cycle, the set wins.
- R6: `irq` equals `sts` when `irq_en`=1 and is 0 when `irq_en`=0.
- R7: On transmit, an odd-frame timeslot-0 bit at position 3+i (i=0..4) whose select bit `tx_sa_sel[i]` is 1 carries bit 4-i of transmit table entry {t, `tx_frm`[3:1]}. Here t is a multiframe parity that starts at 0 after reset and toggles after each valid frame-15 timeslot-0 position-7 cycle. A cleared select bit passes `sys_bit` through.
- R8: Every transmit position that is not an odd-frame timeslot-0 bit at positions 3 to 7 outputs `sys_bit`, whatever the selects and the table hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive bit strobe |
| rx_bit | input | 1 | Receive data bit |
| rx_slot0 | input | 1 | Current receive bit lies in timeslot 0 |
| rx_bitpos | input | 3 | Bit position in the timeslot, 0 = first |
| rx_frm | input | 4 | Frame number in the multiframe |
| rx_aligned | input | 1 | Aligner reports frame alignment |
| snap_addr | input | 4 | Snapshot read entry |
| snap_data | output | 5 | Snapshot entry {Sa4..Sa8} |
| sts_clr | input | 1 | Write-one-to-clear for the status flag |
| irq_en | input | 1 | Interrupt mask, 1 = enabled |
| sts | output | 1 | Snapshot-updated status flag |
| irq | output | 1 | Masked interrupt |
| txs_wr | input | 1 | Transmit table write strobe |
| txs_addr | input | 4 | Transmit table write entry |
| txs_data | input | 5 | Transmit table write data {Sa4..Sa8} |
| tx_valid | input | 1 | Transmit bit strobe |
| tx_slot0 | input | 1 | Current transmit bit lies in timeslot 0 |
| tx_bitpos | input | 3 | Transmit bit position in the timeslot |
| tx_frm | input | 4 | Transmit frame number in the multiframe |
| tx_sa_sel | input | 5 | Per-Sa source select, bit 0 = Sa4, 1 = table |
| sys_bit | input | 1 | System-side transmit bit |
| tx_bit | output | 1 | Outgoing transmit bit |

## Verification
A wrong capture index or column puts a value in the wrong snapshot entry or the wrong bit. That shows on `snap_data` as soon as the first full capture completes, about 290 strobes after the start. A bad active or multiframe-phase state shows as a `sts` flag that rises early, rises late or fails to rise. An aborted capture that still updates the snapshot shows up the same way. A wrong transmit parity or table index corrupts `tx_bit` in the same cycle the Sa position is presented, and the error is visible by the second multiframe.

// File: rtl/e1sa_pkg.sv
package e1sa_pkg;
    localparam int SA_W      = 5;   // Sa4..Sa8
    localparam int MF_FRAMES = 16;
    localparam int CAP_MF    = 2;
    localparam int ENTRIES   = CAP_MF * MF_FRAMES / 2;
    localparam int IDX_W     = $clog2(ENTRIES);
    localparam logic [2:0] SA_FIRST_POS = 3'd3;
    localparam logic [2:0] SA_LAST_POS  = 3'd7;

    typedef logic [SA_W-1:0] sa_entry_t;
    typedef logic [IDX_W-1:0] sa_idx_t;

    typedef struct packed {
        logic       valid;
        logic       slot0;
        logic [2:0] bitpos;
        logic [3:0] frm;
    } frame_pos_t;

    // True when the position carries one of the Sa bits
    function automatic logic is_sa_pos(frame_pos_t p);
        return p.valid && p.slot0 && p.frm[0] && (p.bitpos >= SA_FIRST_POS);
    endfunction

    // Entry bit that a Sa position maps to (Sa4 -> 4 ... Sa8 -> 0)
    function automatic logic [2:0] sa_col(logic [2:0] bitpos);
        return 3'd7 - bitpos;
    endfunction
endpackage

// File: rtl/e1sa_rx_capture.sv
module e1sa_rx_capture
    import e1sa_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  frame_pos_t               pos,
    input  logic                     rx_bit,
    input  logic                     rx_aligned,
    input  sa_idx_t                  rd_idx,
    output sa_entry_t                rd_data,
    output logic                     cap_done
);
    sa_entry_t [ENTRIES-1:0] work_q, work_d, snap_q;
    logic    active_q, mf_q;
    logic    wr_en, mf_start, abort;
    sa_idx_t wr_idx;

    assign abort    = pos.valid && !rx_aligned;
    assign mf_start = pos.valid && rx_aligned && pos.slot0 &&
                      (pos.frm == 4'd0) && (pos.bitpos == 3'd0);
    assign wr_en    = active_q && rx_aligned && is_sa_pos(pos);
    assign wr_idx   = {mf_q, pos.frm[3:1]};
    assign cap_done = wr_en && mf_q && (pos.frm == 4'(MF_FRAMES-1)) &&
                      (pos.bitpos == SA_LAST_POS);

    always_comb begin
        work_d = work_q;
        if (wr_en)
            work_d[wr_idx][sa_col(pos.bitpos)] = rx_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q   <= '0;
            snap_q   <= '0;
            active_q <= 1'b0;
            mf_q     <= 1'b0;
        end else begin
            work_q <= work_d;
            if (abort) begin
                active_q <= 1'b0;
            end else if (cap_done) begin
                active_q <= 1'b0;
                snap_q   <= work_d;
            end else if (mf_start) begin
                if (!active_q) begin
                    active_q <= 1'b1;
                    mf_q     <= 1'b0;
                end else begin
                    mf_q     <= 1'b1;
                end
            end
        end
    end

    assign rd_data = snap_q[rd_idx];

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap_done |=> $stable(snap_q)); // R3
    AST_DONE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        cap_done |-> rx_aligned); // R4
endmodule

// File: rtl/e1sa_irq.sv
module e1sa_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_w1c,
    input  logic irq_en,
    output logic sts,
    output logic irq
);
    logic sts_q;

    always_ff @(posedge clk) begin
        if (rst)
            sts_q <= 1'b0;
        else if (set_evt)
            sts_q <= 1'b1;
        else if (clr_w1c)
            sts_q <= 1'b0;
    end

    assign sts = sts_q;
    assign irq = sts_q & irq_en;

    AST_STS_SET: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> sts_q); // R5
    AST_STS_W1C: assert property (@(posedge clk) disable iff (rst)
        (clr_w1c && !set_evt) |=> !sts_q); // R5
endmodule

// File: rtl/e1sa_tx_insert.sv
module e1sa_tx_insert
    import e1sa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  sa_idx_t    wr_idx,
    input  sa_entry_t  wr_data,
    input  frame_pos_t pos,
    input  sa_entry_t  sel,
    input  logic       sys_bit,
    output logic       tx_bit
);
    sa_entry_t [ENTRIES-1:0] tbl_q;
    logic      mf_q;
    sa_idx_t   rd_idx;
    sa_entry_t cur;
    logic [SA_W-1:0] hit, pick;

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_q <= '0;
            mf_q  <= 1'b0;
        end else begin
            if (wr_en)
                tbl_q[wr_idx] <= wr_data;
            if (pos.valid && pos.slot0 && (pos.frm == 4'(MF_FRAMES-1)) &&
                (pos.bitpos == SA_LAST_POS))
                mf_q <= ~mf_q;
        end
    end

    assign rd_idx = {mf_q, pos.frm[3:1]};
    assign cur    = tbl_q[rd_idx];

    for (genvar i = 0; i < SA_W; i++) begin : g_col
        assign hit[i]  = is_sa_pos(pos) && (pos.bitpos == SA_FIRST_POS + 3'(i)) && sel[i];
        assign pick[i] = hit[i] & cur[SA_W-1-i];
    end

    assign tx_bit = (|hit) ? (|pick) : sys_bit;

    AST_TX_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        (sel == '0) |-> (tx_bit == sys_bit)); // R7
endmodule

// File: rtl/e1sa_datalink.sv
module e1sa_datalink
    import e1sa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic       rx_bit,
    input  logic       rx_slot0,
    input  logic [2:0] rx_bitpos,
    input  logic [3:0] rx_frm,
    input  logic       rx_aligned,
    input  logic [3:0] snap_addr,
    output logic [4:0] snap_data,
    input  logic       sts_clr,
    input  logic       irq_en,
    output logic       sts,
    output logic       irq,
    input  logic       txs_wr,
    input  logic [3:0] txs_addr,
    input  logic [4:0] txs_data,
    input  logic       tx_valid,
    input  logic       tx_slot0,
    input  logic [2:0] tx_bitpos,
    input  logic [3:0] tx_frm,
    input  logic [4:0] tx_sa_sel,
    input  logic       sys_bit,
    output logic       tx_bit
);
    frame_pos_t rx_pos, tx_pos;
    logic       cap_done;

    assign rx_pos = '{valid: rx_valid, slot0: rx_slot0, bitpos: rx_bitpos, frm: rx_frm};
    assign tx_pos = '{valid: tx_valid, slot0: tx_slot0, bitpos: tx_bitpos, frm: tx_frm};

    e1sa_rx_capture u_rx (
        .clk(clk), .rst(rst), .pos(rx_pos), .rx_bit(rx_bit),
        .rx_aligned(rx_aligned), .rd_idx(snap_addr), .rd_data(snap_data),
        .cap_done(cap_done)
    );

    e1sa_irq u_irq (
        .clk(clk), .rst(rst), .set_evt(cap_done), .clr_w1c(sts_clr),
        .irq_en(irq_en), .sts(sts), .irq(irq)
    );

    e1sa_tx_insert u_tx (
        .clk(clk), .rst(rst), .wr_en(txs_wr), .wr_idx(txs_addr),
        .wr_data(txs_data), .pos(tx_pos), .sel(tx_sa_sel),
        .sys_bit(sys_bit), .tx_bit(tx_bit)
    );

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq); // R6
endmodule

// File: tb/sim_e1sa_datalink.sv
module sim_e1sa_datalink;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 0, rx_bit = 0, rx_slot0 = 0, rx_aligned = 0;
    logic [2:0] rx_bitpos = 0;
    logic [3:0] rx_frm = 0;
    logic [3:0] snap_addr = 0;
    logic [4:0] snap_data;
    logic sts_clr = 0, irq_en = 1, sts, irq;
    logic txs_wr = 0;
    logic [3:0] txs_addr = 0;
    logic [4:0] txs_data = 0;
    logic tx_valid = 0, tx_slot0 = 0, sys_bit = 0, tx_bit;
    logic [2:0] tx_bitpos = 0;
    logic [3:0] tx_frm = 0;
    logic [4:0] tx_sa_sel = 0;

    int n_tests = 0;
    int n_fail  = 0;
    logic [4:0] tbl [16];
    logic tx_mf = 0;

    always #2 clk = ~clk;

    e1sa_datalink u0 (.*);

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [4:0] pat(int seed, int e);
        return 5'((e * 11 + seed * 7 + 3) ^ (e << 1) ^ seed);
    endfunction

    task automatic rx_put(logic v, logic s0, int bp, int f, logic b, logic al, logic clr);
        @(negedge clk);
        rx_valid = v; rx_slot0 = s0; rx_bitpos = 3'(bp); rx_frm = 4'(f);
        rx_bit = b; rx_aligned = al; sts_clr = clr;
    endtask

    task automatic rx_idle();
        @(negedge clk);
        rx_valid = 0; sts_clr = 0; rx_aligned = 1;
    endtask

    // One multiframe; frame drop_f is sent misaligned; clr_last pulses sts_clr on final bit
    task automatic send_mf(int seed, int m, int drop_f, bit clr_last);
        for (int f = 0; f < 16; f++) begin
            for (int bp = 0; bp < 8; bp++) begin
                logic b;
                logic [4:0] v;
                v = pat(seed, m * 8 + f / 2);
                b = (f % 2 == 1 && bp >= 3) ? v[7 - bp] : 1'b1;
                rx_put(1, 1, bp, f, b, f != drop_f, clr_last && f == 15 && bp == 7);
            end
            // non-slot0 bit that must be ignored
            rx_put(1, 0, 4, f, ~pat(seed, m * 8 + f / 2)[3], f != drop_f, 0);
        end
        rx_idle();
    endtask

    task automatic check_snap(string req, int seed);
        for (int e = 0; e < 16; e++) begin
            @(negedge clk);
            snap_addr = 4'(e);
            #1;
            chk(req, snap_data, pat(seed, e));
        end
    endtask

    task automatic t_reset();
        for (int e = 0; e < 16; e++) begin
            @(negedge clk);
            snap_addr = 4'(e);
            #1;
            chk("R1 snapshot", snap_data, 0);
        end
        chk("R1 sts", sts, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_capture();
        send_mf(1, 0, -1, 0);
        send_mf(1, 1, -1, 0);
        check_snap("R2 entry", 1);
        chk("R5 sts set", sts, 1);
        chk("R6 irq enabled", irq, 1);
    endtask

    task automatic t_mask_clear();
        @(negedge clk); irq_en = 0; #1;
        chk("R6 irq masked", irq, 0);
        chk("R6 sts kept", sts, 1);
        @(negedge clk); irq_en = 1; #1;
        chk("R6 irq unmasked", irq, 1);
        @(negedge clk); sts_clr = 1;
        @(negedge clk); sts_clr = 0; #1;
        chk("R5 w1c", sts, 0);
        chk("R6 irq after clear", irq, 0);
    endtask

    task automatic t_double_buffer();
        send_mf(2, 0, -1, 0);
        check_snap("R3 stable mid-capture", 1);
        chk("R3 no early sts", sts, 0);
        send_mf(2, 1, -1, 0);
        check_snap("R3 new snapshot", 2);
        chk("R5 sts second", sts, 1);
        @(negedge clk); sts_clr = 1;
        @(negedge clk); sts_clr = 0;
    endtask

    task automatic t_misalign();
        send_mf(3, 0, -1, 0);
        send_mf(3, 1, 5, 0);
        chk("R4 no sts after abort", sts, 0);
        check_snap("R4 snapshot unchanged", 2);
        send_mf(4, 0, -1, 0);
        send_mf(4, 1, -1, 0);
        check_snap("R4 recapture", 4);
        chk("R4 sts after recapture", sts, 1);
        @(negedge clk); sts_clr = 1;
        @(negedge clk); sts_clr = 0;
    endtask

    task automatic t_set_wins();
        send_mf(5, 0, -1, 0);
        send_mf(5, 1, -1, 1);
        chk("R5 set wins over clear", sts, 1);
        check_snap("R2 entry seed5", 5);
    endtask

    task automatic tx_walk(string req, logic [4:0] sel, int sysmode);
        @(negedge clk); tx_sa_sel = sel;
        for (int m = 0; m < 2; m++)
            for (int f = 0; f < 16; f++)
                for (int bp = 0; bp < 9; bp++) begin
                    logic s0, exp, sb;
                    int pb;
                    s0 = (bp < 8);
                    pb = s0 ? bp : 5;
                    sb = (sysmode == 2) ? 1'(f + bp) : 1'(sysmode);
                    @(negedge clk);
                    tx_valid = 1; tx_slot0 = s0; tx_bitpos = 3'(pb);
                    tx_frm = 4'(f); sys_bit = sb;
                    #1;
                    if (s0 && f % 2 == 1 && pb >= 3 && sel[pb - 3])
                        exp = tbl[{tx_mf, 3'(f / 2)}][7 - pb];
                    else
                        exp = sb;
                    if (s0 && f % 2 == 1 && pb >= 3)
                        chk(req, tx_bit, exp);
                    else
                        chk("R8 non-Sa passthrough", tx_bit, exp);
                    if (s0 && f == 15 && pb == 7) tx_mf = ~tx_mf;
                end
        @(negedge clk); tx_valid = 0;
    endtask

    task automatic t_tx();
        for (int e = 0; e < 16; e++) begin
            @(negedge clk);
            tbl[e] = pat(9, e) ^ 5'(e);
            txs_wr = 1; txs_addr = 4'(e); txs_data = tbl[e];
        end
        @(negedge clk); txs_wr = 0;
        tx_walk("R7 all from table", 5'b11111, 0);
        tx_walk("R7 mixed select", 5'b10101, 2);
        tx_walk("R7 none selected", 5'b00000, 1);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_capture();
        t_mask_clear();
        t_double_buffer();
        t_misalign();
        t_set_wins();
        t_tx();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule